// File: doc/BRIEF.md
# Single-Cycle Register-Register Datapath

This block is a minimal processor core that completes one register-to-register instruction in every clock cycle. A word counter forms the program counter. The counter drives the instruction memory address. The 32-bit word that comes back is split into its operation, source, destination, shift-amount and function fields. Two source registers are read from a 32-entry register file. An arithmetic unit computes a sum, a difference and a bitwise OR side by side, and the decoded function field steers a selector that picks one of them. The chosen value is written to the destination register on the next rising edge.

The register file has no load path, so at reset each register is seeded with its own index. Register 0 is the exception and holds zero. From these seeds, programs can build any value with the three operations. A registered debug port lets the surrounding logic, or a bench, observe any register without changing it. Any other opcode or function code runs as a no-operation, and the counter still moves on.

Top module: `rr_core`

## Requirements
- R1: While `rst` is high on a rising edge, the program counter goes to 0 and each register k (0 to 31) is loaded with the value k. Register 0 therefore holds zero.
- R2: `imem_addr` is the byte program counter divided by four. It goes up by one on every rising edge with `rst` low, and it wraps around at its width.
- R3: An instruction with opcode bits [31:26] = 0 and function bits [5:0] = 0x21 writes R[rs] + R[rt], modulo 2^32, into R[rd]. Here rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11]. No overflow indication exists.
- R4: An instruction with opcode 0 and function 0x23 writes R[rs] - R[rt], modulo 2^32, into R[rd].
- R5: An instruction with opcode 0 and function 0x25 writes the bitwise OR of R[rs] and R[rt] into R[rd].
- R6: An instruction with a nonzero opcode, or with opcode 0 and any function other than 0x21, 0x23 or 0x25, leaves every register unchanged.
- R7: An instruction with rd = 0 leaves register 0 at zero. Reading register 0 always returns zero.
- R8: Source operands are the register values held before the instruction's own write. A result is visible to the instruction in the following cycle.
- R9: The shift-amount field, bits [10:6], has no effect on the three supported operations.
- R10: `dbg_data` shows the value that register `dbg_sel` held just before the most recent rising edge. It therefore lags a change of `dbg_sel` by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 30 | Word address of the instruction to fetch |
| imem_data | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| dbg_sel | input | 5 | Register index to observe |
| dbg_data | output | 32 | Registered contents of the selected register |

## Verification
The embedded properties assume three things. The instruction memory answers combinationally, in the same cycle. `rst` is held high for at least one edge before the first check. The write-back property also assumes the register array sees each write on the edge that follows. The bench therefore drives `imem_data` and `dbg_sel` only at falling edges and starts with several reset cycles. It spaces each table instruction with a no-operation word (opcode 0x3F), so that the debug read of a result is never disturbed by a following write.

// File: rtl/rr_core_pkg.sv
package rr_core_pkg;

  localparam int INSN_W = 32;
  localparam int OPC_W  = 6;
  localparam int RIDX_W = 5;
  localparam int SHF_W  = 5;
  localparam int FUN_W  = 6;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [RIDX_W-1:0] dst;
    logic [SHF_W-1:0]  shf;
    logic [FUN_W-1:0]  fun;
  } insn_t;

  typedef enum logic [1:0] {
    PICK_SUM  = 2'd0,
    PICK_DIFF = 2'd1,
    PICK_OR   = 2'd2
  } pick_t;

  localparam int NUM_LANES = 3;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
  localparam logic [FUN_W-1:0] FUN_SUM  = 6'h21;
  localparam logic [FUN_W-1:0] FUN_DIFF = 6'h23;
  localparam logic [FUN_W-1:0] FUN_OR   = 6'h25;

endpackage

// File: rtl/rr_fetch_ctr.sv
module rr_fetch_ctr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-3:0] word_addr
);

  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) wcnt <= '0;
    else     wcnt <= wcnt + WA_W'(1);
  end

  assign word_addr = wcnt;

  // R1
  pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wcnt == '0));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (wcnt == $past(wcnt) + WA_W'(1)));

endmodule

// File: rtl/rr_decode.sv
module rr_decode
  import rr_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] insn,
  output logic [RIDX_W-1:0] rd_a_idx,
  output logic [RIDX_W-1:0] rd_b_idx,
  output logic [RIDX_W-1:0] wr_idx,
  output logic              wr_en,
  output pick_t             pick
);

  insn_t f;
  assign f = insn_t'(insn);

  assign rd_a_idx = f.src_a;
  assign rd_b_idx = f.src_b;
  assign wr_idx   = f.dst;

  always_comb begin
    wr_en = 1'b0;
    pick  = PICK_SUM;
    if (f.opc == OPC_REG) begin
      unique case (f.fun)
        FUN_SUM:  begin wr_en = 1'b1; pick = PICK_SUM;  end
        FUN_DIFF: begin wr_en = 1'b1; pick = PICK_DIFF; end
        FUN_OR:   begin wr_en = 1'b1; pick = PICK_OR;   end
        default:  begin wr_en = 1'b0; pick = PICK_SUM;  end
      endcase
    end
  end

  // R6
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (f.opc != OPC_REG) |-> !wr_en);

  // R9
  shamt_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    ((f.shf != '0) && (f.opc == OPC_REG) && (f.fun == FUN_OR)) |-> wr_en);

endmodule

// File: rtl/rr_alu.sv
module rr_alu
  import rr_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  pick_t             pick,
  output logic [DATA_W-1:0] res
);

  localparam int LANE_SLOTS = 1 << $bits(pick_t);

  logic [DATA_W-1:0] lane [LANE_SLOTS];

  assign lane[PICK_SUM]  = opa + opb;
  assign lane[PICK_DIFF] = opa - opb;
  assign lane[PICK_OR]   = opa | opb;

  generate
    for (genvar s = NUM_LANES; s < LANE_SLOTS; s++) begin : g_spare
      assign lane[s] = '0;
    end
  endgenerate

  assign res = lane[pick];

endmodule

// File: rtl/rr_regbank.sv
module rr_regbank #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(REG_CNT)-1:0] ra_idx,
  output logic [DATA_W-1:0]          ra_val,
  input  logic [$clog2(REG_CNT)-1:0] rb_idx,
  output logic [DATA_W-1:0]          rb_val,
  input  logic [$clog2(REG_CNT)-1:0] rv_idx,
  output logic [DATA_W-1:0]          rv_val,
  input  logic                       we,
  input  logic [$clog2(REG_CNT)-1:0] wa,
  input  logic [DATA_W-1:0]          wd
);

  localparam int IDX_W = $clog2(REG_CNT);

  logic [DATA_W-1:0] cells [REG_CNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < REG_CNT; k++) cells[k] <= DATA_W'(k);
    end else if (we && (wa != '0)) begin
      cells[wa] <= wd;
    end
  end

  assign ra_val = cells[ra_idx];
  assign rb_val = cells[rb_idx];
  assign rv_val = cells[rv_idx];

  // R7
  r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == IDX_W'(0)) |-> (ra_val == '0));

  // R3
  wb_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (we && (wa != '0)) |=> (cells[$past(wa)] == $past(wd)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!we && (ra_idx == rb_idx)) |=> (cells[$past(ra_idx)] == $past(ra_val)));

endmodule

// File: rtl/rr_core.sv
module rr_core
  import rr_core_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int REG_CNT = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [ADDR_W-3:0]          imem_addr,
  input  logic [INSN_W-1:0]          imem_data,
  input  logic [$clog2(REG_CNT)-1:0] dbg_sel,
  output logic [DATA_W-1:0]          dbg_data
);

  localparam int IDX_W = $clog2(REG_CNT);

  logic [IDX_W-1:0]  a_idx, b_idx, d_idx;
  logic              d_we;
  pick_t             sel;
  logic [DATA_W-1:0] a_val, b_val, y_val, view_val;

  rr_fetch_ctr #(.ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .word_addr (imem_addr)
  );

  rr_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .insn     (imem_data),
    .rd_a_idx (a_idx),
    .rd_b_idx (b_idx),
    .wr_idx   (d_idx),
    .wr_en    (d_we),
    .pick     (sel)
  );

  rr_regbank #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ra_idx (a_idx),
    .ra_val (a_val),
    .rb_idx (b_idx),
    .rb_val (b_val),
    .rv_idx (dbg_sel),
    .rv_val (view_val),
    .we     (d_we),
    .wa     (d_idx),
    .wd     (y_val)
  );

  rr_alu #(.DATA_W(DATA_W)) u_alu (
    .opa  (a_val),
    .opb  (b_val),
    .pick (sel),
    .res  (y_val)
  );

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= view_val;
  end

  // R10
  dbg_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dbg_sel) == IDX_W'(0)) |-> (dbg_data == '0));

endmodule

// File: tb/tb_rr_core.sv
module tb_rr_core;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam logic [31:0] NOP = 32'hFC00_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:0] imem_addr;
  logic [31:0] imem_data = NOP;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [29:0] exp_wa = '0;
  logic [31:0] mdl [32];

  rr_core dut (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dbg_sel   (dbg_sel),
    .dbg_data  (dbg_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) exp_wa <= '0;
    else     exp_wa <= exp_wa + 30'd1;
  end

  // {tag, op, rs, rt, rd, shamt, func}
  localparam logic [35:0] VEC [NV] = '{
    {4'd4, 6'd0, 5'd0,  5'd1,  5'd10, 5'd0,  6'h23},
    {4'd3, 6'd0, 5'd10, 5'd2,  5'd11, 5'd0,  6'h21},
    {4'd5, 6'd0, 5'd10, 5'd5,  5'd12, 5'd0,  6'h25},
    {4'd5, 6'd0, 5'd6,  5'd9,  5'd13, 5'd0,  6'h25},
    {4'd3, 6'd0, 5'd10, 5'd10, 5'd14, 5'd0,  6'h21},
    {4'd4, 6'd0, 5'd3,  5'd7,  5'd15, 5'd0,  6'h23},
    {4'd8, 6'd0, 5'd3,  5'd3,  5'd3,  5'd0,  6'h21},
    {4'd8, 6'd0, 5'd3,  5'd4,  5'd16, 5'd0,  6'h21},
    {4'd9, 6'd0, 5'd1,  5'd2,  5'd17, 5'd31, 6'h21},
    {4'd6, 6'd0, 5'd8,  5'd9,  5'd18, 5'd0,  6'h20},
    {4'd6, 6'd2, 5'd8,  5'd9,  5'd19, 5'd0,  6'h21},
    {4'd7, 6'd0, 5'd1,  5'd0,  5'd0,  5'd0,  6'h23}
  };

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every falling edge: drive inputs; address check against the counting model (R2)
  task automatic tick(input logic [31:0] ins, input logic [4:0] sel);
    @(negedge clk);
    chk("R2", {2'b00, imem_addr}, {2'b00, exp_wa});
    imem_data = ins;
    dbg_sel   = sel;
  endtask

  task automatic model_reset();
    for (int k = 0; k < 32; k++) mdl[k] = 32'(k);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    imem_data = NOP;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic check_all_regs(input string req);
    for (int k = 0; k < 32; k++) begin
      tick(NOP, 5'(k));
      @(negedge clk);
      chk(req, dbg_data, mdl[k]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: address starts at zero right after reset
    chk("R1", {2'b00, imem_addr}, 32'd0);
    // R1: seeded register contents
    check_all_regs("R1");

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [35:0] e;
      logic [5:0] op, fn;
      logic [4:0] rs, rt, rd;
      logic [31:0] a, b, r;
      bit ok;
      e  = VEC[v];
      op = e[31:26]; rs = e[25:21]; rt = e[20:16]; rd = e[15:11]; fn = e[5:0];
      a = mdl[rs]; b = mdl[rt];
      ok = 1'b1;
      if (op != 6'd0) ok = 1'b0;
      else if (fn == 6'h21) r = a + b;
      else if (fn == 6'h23) r = a - b;
      else if (fn == 6'h25) r = a | b;
      else ok = 1'b0;
      if (ok && rd != 5'd0) mdl[rd] = r;
      tick(e[31:0], rd);
      tick(NOP, rd);
      @(negedge clk);
      chk(tag_name(int'(e[35:32])), dbg_data, mdl[rd]);
    end

    // R6 R7: nothing else disturbed by the table
    check_all_regs("R6");

    // R10: one-cycle lag of the debug view
    tick(NOP, 5'd13);
    tick(NOP, 5'd14);
    #1 chk("R10", dbg_data, mdl[13]);
    @(negedge clk);
    chk("R10", dbg_data, mdl[14]);

    // R8: back-to-back dependency without spacing
    tick({6'd0, 5'd1, 5'd1, 5'd20, 5'd0, 6'h21}, 5'd0);
    mdl[20] = mdl[1] + mdl[1];
    tick({6'd0, 5'd20, 5'd20, 5'd21, 5'd0, 6'h21}, 5'd21);
    mdl[21] = mdl[20] + mdl[20];
    tick(NOP, 5'd21);
    @(negedge clk);
    chk("R8", dbg_data, mdl[21]);

    // R1: reset mid-run restores seeds and address
    do_reset();
    chk("R1", {2'b00, imem_addr}, 32'd0);
    tick(NOP, 5'd20);
    @(negedge clk);
    chk("R1", dbg_data, 32'd20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule